// File: doc/BRIEF.md
# RGB to YCbCr Colour Matrix Converter

This block converts a stream of full-range 8-bit RGB pixels into one of three limited-range encodings: YCbCr with standard-definition weights, YCbCr with high-definition weights, or RGB compressed into the 16..235 video range. A 3x3 matrix and three offsets are applied to every pixel. The result is rounded, clamped to the legal video range and registered. Each output mode reads its matrix from a small programmable bank. Reset loads the bank with the three standard matrices, and software may overwrite any byte afterwards.

When conversion is disabled, or the reserved mode code is selected, pixels pass through unchanged. This is the path for full-range RGB output. A separate control bit exchanges the first and third output components. The enable, swap and mode controls are sampled with each pixel, so a stream may change mode from one pixel to the next. Horizontal sync, vertical sync and data enable travel through the same number of registers as the pixel, so they stay aligned with it.

Top module: `rgb_ycc_conv`

## Requirements
- R1: While `rst` is high, every output is held at zero. Each rst cycle reloads all 72 bank bytes with the default matrices of R3, R4 and R5.
- R2: A pixel and its three sync bits, sampled at clock edge N, appear on the outputs after edge N+3.
- R3: Mode 0 uses these defaults, in units of 1/1024. Row 0 is (263, 516, 100) with offset 16. Row 1 is (-152, -298, 450) with offset 128. Row 2 is (450, -377, -73) with offset 128. Each row weights (R, G, B) and produces c0, c1 and c2 in that order.
- R4: Mode 1 uses these defaults. Row 0 is (187, 629, 63) with offset 16. Row 1 is (-103, -346, 450) with offset 128. Row 2 is (450, -409, -41) with offset 128.
- R5: Mode 2 gives limited-range RGB. It uses the diagonal gain 879 (219/255) and offset 16 on every row, and all other gains are zero.
- R6: When `csc_en` is low, or `mode` is 3, the output equals the input pixel (c0=R, c1=G, c2=B), subject only to R9.
- R7: Each component is computed as floor((sum of gain*input + offset*1024 + 512) / 1024). An exact half therefore rounds up.
- R8: The converted c0 is clamped to 16..235. In modes 0 and 1, c1 and c2 are clamped to 16..240. In mode 2, c1 and c2 are clamped to 16..235.
- R9: When `swap_en` is high, the final c0 and c2 are exchanged. This applies to both converted and passed-through pixels.
- R10: A bank write with `cw_en` high stores `cw_data` at byte address `cw_addr` = mode*24 + entry*2 + half. Half 0 is the low byte. Entries run row0 gains R, G, B, then row0 offset, then rows 1 and 2 in the same order. Each 16-bit entry uses bit 15 as the sign and bits 11:0 as the magnitude. Writes to addresses 72 and above are ignored. A written value applies to pixels sampled on later edges.
- R11: `csc_en`, `swap_en` and `mode` are sampled together with the pixel. Consecutive pixels may use different settings without affecting each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csc_en | input | 1 | Enables matrix conversion for this pixel |
| swap_en | input | 1 | Exchanges output components c0 and c2 |
| mode | input | 2 | 0 SD YCbCr, 1 HD YCbCr, 2 limited RGB, 3 pass-through |
| cw_en | input | 1 | Bank byte write strobe |
| cw_addr | input | 7 | Bank byte address |
| cw_data | input | 8 | Bank byte value |
| in_r | input | 8 | Red input |
| in_g | input | 8 | Green input |
| in_b | input | 8 | Blue input |
| in_hs | input | 1 | Horizontal sync input |
| in_vs | input | 1 | Vertical sync input |
| in_de | input | 1 | Data enable input |
| out_c0 | output | 8 | Y, or R' in mode 2 |
| out_c1 | output | 8 | Cb, or G' in mode 2 |
| out_c2 | output | 8 | Cr, or B' in mode 2 |
| out_hs | output | 1 | Delayed horizontal sync |
| out_vs | output | 1 | Delayed vertical sync |
| out_de | output | 1 | Delayed data enable |

## Verification
Every result, whether a converted pixel, a pass-through pixel or a sync bit, is due exactly three edges after the edge that samples its input. The bench drives inputs on the falling edge. In streaming, each falling edge compares the outputs against the vector driven three falling edges earlier. Directed tests wait three rising edges and read at the next falling edge. A bank write takes effect one edge after it is driven, so the bench drives each test pixel only after the write cycle has closed.

// File: rtl/rgb_ycc_pkg.sv
package rgb_ycc_pkg;

    localparam int PIX_W          = 8;
    localparam int NUM_MODES      = 3;
    localparam int NUM_ROWS       = 3;
    localparam int ROW_TERMS      = 4;                      // three gains and one offset
    localparam int ENTRIES        = NUM_ROWS * ROW_TERMS;
    localparam int BYTES_PER_MODE = ENTRIES * 2;
    localparam int BANK_BYTES     = NUM_MODES * BYTES_PER_MODE;
    localparam int ADDR_W         = $clog2(BANK_BYTES);
    localparam int ENTRY_W        = 16;
    localparam int MAG_W          = 12;
    localparam int SIGN_BIT       = ENTRY_W - 1;
    localparam int FRAC_W         = 10;
    localparam int COEF_W         = MAG_W + 1;
    localparam int PROD_W         = COEF_W + PIX_W + 1;
    localparam int ACC_W          = COEF_W + FRAC_W + 3;
    localparam int LAT            = 3;

    localparam int LEVEL_MIN  = 16;
    localparam int LUMA_MAX   = 235;
    localparam int CHROMA_MAX = 240;

    typedef logic [PIX_W-1:0]   chan_t;
    typedef logic [ENTRY_W-1:0] entry_t;
    typedef logic signed [ACC_W-1:0] acc_t;
    typedef logic signed [COEF_W-1:0] coef_t;

    typedef struct packed {
        chan_t c0;
        chan_t c1;
        chan_t c2;
    } pix_t;

    typedef struct packed {
        logic hs;
        logic vs;
        logic de;
    } sync_t;

    typedef enum logic [1:0] {
        MODE_SD   = 2'd0,
        MODE_HD   = 2'd1,
        MODE_LRGB = 2'd2,
        MODE_PASS = 2'd3
    } mode_e;

    typedef struct packed {
        logic  en;
        logic  swap;
        mode_e mode;
    } ctl_t;

    typedef logic [ROW_TERMS-1:0][ENTRY_W-1:0] row_t;
    typedef logic [NUM_MODES-1:0][ENTRIES-1:0][ENTRY_W-1:0] bank_t;

    // Default gains in 1/1024 units, offsets in integer levels
    localparam int SD_DEF [ENTRIES] = '{263, 516, 100, 16,
                                        -152, -298, 450, 128,
                                        450, -377, -73, 128};
    localparam int HD_DEF [ENTRIES] = '{187, 629, 63, 16,
                                        -103, -346, 450, 128,
                                        450, -409, -41, 128};
    localparam int LRGB_DEF [ENTRIES] = '{879, 0, 0, 16,
                                          0, 879, 0, 16,
                                          0, 0, 879, 16};

    function automatic entry_t to_sign_mag(input int v);
        entry_t r;
        r = '0;
        if (v < 0) begin
            r[SIGN_BIT]    = 1'b1;
            r[MAG_W-1:0]   = MAG_W'(-v);
        end else begin
            r[MAG_W-1:0]   = MAG_W'(v);
        end
        return r;
    endfunction

    function automatic entry_t default_entry(input int m, input int e);
        int v;
        case (m)
            0:       v = SD_DEF[e];
            1:       v = HD_DEF[e];
            default: v = LRGB_DEF[e];
        endcase
        return to_sign_mag(v);
    endfunction

    function automatic coef_t decode(input entry_t e);
        coef_t mag;
        mag = $signed({1'b0, e[MAG_W-1:0]});
        return e[SIGN_BIT] ? -mag : mag;
    endfunction

    function automatic chan_t clamp(input acc_t v, input int hi);
        if (v < LEVEL_MIN)
            return chan_t'(LEVEL_MIN);
        else if (v > hi)
            return chan_t'(hi);
        else
            return v[PIX_W-1:0];
    endfunction

endpackage

// File: rtl/rgb_ycc_coef_bank.sv
module rgb_ycc_coef_bank
    import rgb_ycc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    output bank_t             coefs
);

    for (genvar g = 0; g < BANK_BYTES; g++) begin : g_byte
        localparam int         M      = g / BYTES_PER_MODE;
        localparam int         E      = (g % BYTES_PER_MODE) / 2;
        localparam int         HALF   = g % 2;
        localparam entry_t     INIT   = default_entry(M, E);
        localparam logic [7:0] INIT_B = (HALF == 1) ? INIT[15:8] : INIT[7:0];

        logic [7:0] q;

        always_ff @(posedge clk) begin
            if (rst)
                q <= INIT_B;
            else if (wr_en && (wr_addr == ADDR_W'(g)))
                q <= wr_data;
        end

        assign coefs[M][E][8*HALF +: 8] = q;
    end

endmodule

// File: rtl/rgb_ycc_row_mac.sv
module rgb_ycc_row_mac
    import rgb_ycc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  pix_t pix,
    input  row_t row,
    output acc_t val_o
);

    localparam acc_t HALF_LSB = acc_t'(1) <<< (FRAC_W - 1);

    chan_t                    x      [3];
    logic signed [PROD_W-1:0] prod_q [3];
    acc_t                     off_q;
    acc_t                     sum;

    assign x[0] = pix.c0;
    assign x[1] = pix.c1;
    assign x[2] = pix.c2;

    // Stage 1: one product per input channel, offset scaled to the fraction
    for (genvar k = 0; k < 3; k++) begin : g_term
        always_ff @(posedge clk) begin
            if (rst)
                prod_q[k] <= '0;
            else
                prod_q[k] <= PROD_W'(decode(row[k])) * PROD_W'($signed({1'b0, x[k]}));
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            off_q <= '0;
        else
            off_q <= ACC_W'(decode(row[ROW_TERMS-1])) <<< FRAC_W;
    end

    // Stage 2: accumulate, add half an LSB, drop the fraction
    always_comb begin
        sum = ACC_W'(prod_q[0]) + ACC_W'(prod_q[1]) + ACC_W'(prod_q[2]) + off_q + HALF_LSB;
    end

    always_ff @(posedge clk) begin
        if (rst)
            val_o <= '0;
        else
            val_o <= sum >>> FRAC_W;
    end

endmodule

// File: rtl/rgb_ycc_out_stage.sv
module rgb_ycc_out_stage
    import rgb_ycc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  ctl_t ctl,
    input  pix_t raw,
    input  acc_t v0,
    input  acc_t v1,
    input  acc_t v2,
    output pix_t pix_o
);

    pix_t sel;
    pix_t nxt;
    int   hi_12;

    always_comb begin
        hi_12 = (ctl.mode == MODE_LRGB) ? LUMA_MAX : CHROMA_MAX;
        if (ctl.en && (ctl.mode != MODE_PASS)) begin
            sel.c0 = clamp(v0, LUMA_MAX);
            sel.c1 = clamp(v1, hi_12);
            sel.c2 = clamp(v2, hi_12);
        end else begin
            sel = raw;
        end
        nxt = sel;
        if (ctl.swap) begin
            nxt.c0 = sel.c2;
            nxt.c2 = sel.c0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            pix_o <= '0;
        else
            pix_o <= nxt;
    end

endmodule

// File: rtl/rgb_ycc_conv.sv
module rgb_ycc_conv
    import rgb_ycc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              csc_en,
    input  logic              swap_en,
    input  logic [1:0]        mode,
    input  logic              cw_en,
    input  logic [ADDR_W-1:0] cw_addr,
    input  logic [7:0]        cw_data,
    input  logic [PIX_W-1:0]  in_r,
    input  logic [PIX_W-1:0]  in_g,
    input  logic [PIX_W-1:0]  in_b,
    input  logic              in_hs,
    input  logic              in_vs,
    input  logic              in_de,
    output logic [PIX_W-1:0]  out_c0,
    output logic [PIX_W-1:0]  out_c1,
    output logic [PIX_W-1:0]  out_c2,
    output logic              out_hs,
    output logic              out_vs,
    output logic              out_de
);

    localparam int CTL_STAGES = LAT - 1;

    bank_t      coefs;
    pix_t       pix_in;
    ctl_t       ctl_in;
    sync_t      sync_in;
    logic [1:0] msel;
    acc_t       row_val [NUM_ROWS];
    pix_t       pix_out;

    pix_t  raw_q  [CTL_STAGES];
    ctl_t  ctl_q  [CTL_STAGES];
    sync_t sync_q [LAT];

    assign pix_in  = '{c0: in_r, c1: in_g, c2: in_b};
    assign ctl_in  = '{en: csc_en, swap: swap_en, mode: mode_e'(mode)};
    assign sync_in = '{hs: in_hs, vs: in_vs, de: in_de};
    assign msel    = (mode == MODE_PASS) ? 2'd0 : mode;

    rgb_ycc_coef_bank u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cw_en),
        .wr_addr (cw_addr),
        .wr_data (cw_data),
        .coefs   (coefs)
    );

    for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row
        rgb_ycc_row_mac u_mac (
            .clk   (clk),
            .rst   (rst),
            .pix   (pix_in),
            .row   (coefs[msel][r*ROW_TERMS +: ROW_TERMS]),
            .val_o (row_val[r])
        );
    end

    // Control and raw pixel follow the two arithmetic stages
    for (genvar s = 0; s < CTL_STAGES; s++) begin : g_ctl
        always_ff @(posedge clk) begin
            if (rst) begin
                raw_q[s] <= '0;
                ctl_q[s] <= '0;
            end else if (s == 0) begin
                raw_q[s] <= pix_in;
                ctl_q[s] <= ctl_in;
            end else begin
                raw_q[s] <= raw_q[(s == 0) ? 0 : s-1];
                ctl_q[s] <= ctl_q[(s == 0) ? 0 : s-1];
            end
        end
    end

    // Syncs take the full latency
    for (genvar s = 0; s < LAT; s++) begin : g_sync
        always_ff @(posedge clk) begin
            if (rst)
                sync_q[s] <= '0;
            else if (s == 0)
                sync_q[s] <= sync_in;
            else
                sync_q[s] <= sync_q[(s == 0) ? 0 : s-1];
        end
    end

    rgb_ycc_out_stage u_out (
        .clk   (clk),
        .rst   (rst),
        .ctl   (ctl_q[CTL_STAGES-1]),
        .raw   (raw_q[CTL_STAGES-1]),
        .v0    (row_val[0]),
        .v1    (row_val[1]),
        .v2    (row_val[2]),
        .pix_o (pix_out)
    );

    assign out_c0 = pix_out.c0;
    assign out_c1 = pix_out.c1;
    assign out_c2 = pix_out.c2;
    assign out_hs = sync_q[LAT-1].hs;
    assign out_vs = sync_q[LAT-1].vs;
    assign out_de = sync_q[LAT-1].de;

endmodule

// File: rtl/rgb_ycc_conv_checker.sv
module rgb_ycc_conv_checker (
    input logic       clk,
    input logic       rst,
    input logic       csc_en,
    input logic       swap_en,
    input logic [1:0] mode,
    input logic [7:0] in_r,
    input logic [7:0] in_g,
    input logic [7:0] in_b,
    input logic       in_hs,
    input logic       in_vs,
    input logic       in_de,
    input logic [7:0] out_c0,
    input logic [7:0] out_c1,
    input logic [7:0] out_c2,
    input logic       out_hs,
    input logic       out_vs,
    input logic       out_de
);

    // Cycles since reset, saturating, so $past never reaches before reset
    logic [1:0] age;

    always_ff @(posedge clk) begin
        if (rst)
            age <= 2'd0;
        else if (age != 2'd3)
            age <= age + 2'd1;
    end

    a_r2_sync_latency: assert property (@(posedge clk) disable iff (rst)
        (age == 2'd3) |->
            ({out_hs, out_vs, out_de} == {$past(in_hs, 3), $past(in_vs, 3), $past(in_de, 3)}));

    a_r6_passthrough: assert property (@(posedge clk) disable iff (rst)
        (age == 2'd3 && !$past(csc_en, 3) && !$past(swap_en, 3)) |->
            (out_c0 == $past(in_r, 3) && out_c1 == $past(in_g, 3) && out_c2 == $past(in_b, 3)));

    a_r9_swap_pass: assert property (@(posedge clk) disable iff (rst)
        (age == 2'd3 && !$past(csc_en, 3) && $past(swap_en, 3)) |->
            (out_c0 == $past(in_b, 3) && out_c1 == $past(in_g, 3) && out_c2 == $past(in_r, 3)));

    a_r8_luma_range: assert property (@(posedge clk) disable iff (rst)
        (age == 2'd3 && $past(csc_en, 3) && $past(mode, 3) != 2'd3 && !$past(swap_en, 3)) |->
            (out_c0 >= 8'd16 && out_c0 <= 8'd235));

    a_r8_chroma_range: assert property (@(posedge clk) disable iff (rst)
        (age == 2'd3 && $past(csc_en, 3) && $past(mode, 3) != 2'd3) |->
            (out_c1 >= 8'd16 && out_c1 <= 8'd240 && out_c2 >= 8'd16 && out_c2 <= 8'd240));

endmodule

bind rgb_ycc_conv rgb_ycc_conv_checker u_chk (
    .clk     (clk),
    .rst     (rst),
    .csc_en  (csc_en),
    .swap_en (swap_en),
    .mode    (mode),
    .in_r    (in_r),
    .in_g    (in_g),
    .in_b    (in_b),
    .in_hs   (in_hs),
    .in_vs   (in_vs),
    .in_de   (in_de),
    .out_c0  (out_c0),
    .out_c1  (out_c1),
    .out_c2  (out_c2),
    .out_hs  (out_hs),
    .out_vs  (out_vs),
    .out_de  (out_de)
);

// File: tb/rgb_ycc_conv_test.sv
module rgb_ycc_conv_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       csc_en = 1'b0, swap_en = 1'b0;
    logic [1:0] mode = 2'd0;
    logic       cw_en = 1'b0;
    logic [6:0] cw_addr = '0;
    logic [7:0] cw_data = '0;
    logic [7:0] in_r = '0, in_g = '0, in_b = '0;
    logic       in_hs = 1'b0, in_vs = 1'b0, in_de = 1'b0;
    logic [7:0] out_c0, out_c1, out_c2;
    logic       out_hs, out_vs, out_de;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;   // 50 MHz

    rgb_ycc_conv uut (
        .clk(clk), .rst(rst), .csc_en(csc_en), .swap_en(swap_en), .mode(mode),
        .cw_en(cw_en), .cw_addr(cw_addr), .cw_data(cw_data),
        .in_r(in_r), .in_g(in_g), .in_b(in_b),
        .in_hs(in_hs), .in_vs(in_vs), .in_de(in_de),
        .out_c0(out_c0), .out_c1(out_c1), .out_c2(out_c2),
        .out_hs(out_hs), .out_vs(out_vs), .out_de(out_de)
    );

    // {en, swap, mode, r, g, b, expected c0, c1, c2}
    localparam int NV = 13;
    localparam logic [51:0] VEC [NV] = '{
        {1'b1, 1'b0, 2'd0, 8'd0,   8'd0,   8'd0,   8'd16,  8'd128, 8'd128},
        {1'b1, 1'b0, 2'd0, 8'd255, 8'd255, 8'd255, 8'd235, 8'd128, 8'd128},
        {1'b1, 1'b0, 2'd0, 8'd255, 8'd0,   8'd0,   8'd81,  8'd90,  8'd240},
        {1'b1, 1'b0, 2'd0, 8'd0,   8'd0,   8'd255, 8'd41,  8'd240, 8'd110},
        {1'b1, 1'b0, 2'd1, 8'd255, 8'd255, 8'd255, 8'd235, 8'd128, 8'd128},
        {1'b1, 1'b0, 2'd1, 8'd255, 8'd0,   8'd0,   8'd63,  8'd102, 8'd240},
        {1'b1, 1'b0, 2'd2, 8'd255, 8'd255, 8'd255, 8'd235, 8'd235, 8'd235},
        {1'b1, 1'b0, 2'd2, 8'd0,   8'd128, 8'd255, 8'd16,  8'd126, 8'd235},
        {1'b0, 1'b0, 2'd0, 8'd12,  8'd34,  8'd56,  8'd12,  8'd34,  8'd56},
        {1'b1, 1'b0, 2'd3, 8'd200, 8'd100, 8'd50,  8'd200, 8'd100, 8'd50},
        {1'b1, 1'b1, 2'd0, 8'd255, 8'd0,   8'd0,   8'd240, 8'd90,  8'd81},
        {1'b0, 1'b1, 2'd1, 8'd1,   8'd2,   8'd3,   8'd3,   8'd2,   8'd1},
        {1'b1, 1'b0, 2'd0, 8'd0,   8'd255, 8'd0,   8'd144, 8'd54,  8'd34}
    };

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic chk_pix(input string tag, input int e0, input int e1, input int e2);
        chk({tag, " c0"}, int'(out_c0), e0);
        chk({tag, " c1"}, int'(out_c1), e1);
        chk({tag, " c2"}, int'(out_c2), e2);
    endtask

    task automatic drive(input logic en, input logic sw, input logic [1:0] m,
                         input logic [7:0] r, input logic [7:0] g, input logic [7:0] b,
                         input logic [2:0] sy);
        csc_en = en; swap_en = sw; mode = m;
        in_r = r; in_g = g; in_b = b;
        {in_hs, in_vs, in_de} = sy;
    endtask

    // Drive one pixel and return at the falling edge after its third rising edge
    task automatic run_px(input logic en, input logic sw, input logic [1:0] m,
                          input logic [7:0] r, input logic [7:0] g, input logic [7:0] b);
        @(negedge clk);
        drive(en, sw, m, r, g, b, 3'b001);
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic bank_wr(input logic [6:0] a, input logic [7:0] d);
        @(negedge clk);
        cw_en = 1'b1; cw_addr = a; cw_data = d;
        @(negedge clk);
        cw_en = 1'b0;
    endtask

    function automatic string vec_tag(input logic [51:0] v);
        string t;
        if (!v[51] || v[49:48] == 2'd3) t = "R6";
        else if (v[49:48] == 2'd0)      t = "R3";
        else if (v[49:48] == 2'd1)      t = "R4";
        else                            t = "R5";
        if (v[50]) t = {t, "+R9"};
        return {t, "+R11"};
    endfunction

    initial begin
        // R1: outputs zero while in reset
        drive(1'b1, 1'b0, 2'd0, 8'd9, 8'd9, 8'd9, 3'b111);
        repeat (3) @(negedge clk);
        chk_pix("R1 reset", 0, 0, 0);
        chk("R1 reset sync", int'({out_hs, out_vs, out_de}), 0);
        rst = 1'b0;

        // Stream: one vector per cycle, result checked three edges later (R2, R11)
        for (int i = 0; i < NV + 3; i++) begin
            @(negedge clk);
            if (i >= 3) begin
                chk_pix($sformatf("%s vec %0d", vec_tag(VEC[i-3]), i-3),
                        int'(VEC[i-3][23:16]), int'(VEC[i-3][15:8]), int'(VEC[i-3][7:0]));
                chk($sformatf("R2 sync vec %0d", i-3), int'({out_hs, out_vs, out_de}), (i-3) % 8);
            end
            if (i < NV)
                drive(VEC[i][51], VEC[i][50], VEC[i][49:48], VEC[i][47:40],
                      VEC[i][39:32], VEC[i][31:24], 3'(i % 8));
            else
                drive(1'b0, 1'b0, 2'd0, 8'd0, 8'd0, 8'd0, 3'b000);
        end

        // R10 + R7: mode 2 red gain set to 512 (0.5); 16.5 -> 17, 17.5 -> 18
        bank_wr(7'd48, 8'h00);
        bank_wr(7'd49, 8'h02);
        run_px(1'b1, 1'b0, 2'd2, 8'd1, 8'd0, 8'd0);
        chk_pix("R7 R10 half up a", 17, 16, 16);
        run_px(1'b1, 1'b0, 2'd2, 8'd3, 8'd0, 8'd0);
        chk_pix("R7 R10 half up b", 18, 16, 16);

        // R8: row-0 offset 250 clamps high, -20 clamps low
        bank_wr(7'd54, 8'hFA);
        run_px(1'b1, 1'b0, 2'd2, 8'd1, 8'd0, 8'd0);
        chk("R8 luma clamp high", int'(out_c0), 235);
        bank_wr(7'd54, 8'h14);
        bank_wr(7'd55, 8'h80);
        run_px(1'b1, 1'b0, 2'd2, 8'd1, 8'd0, 8'd0);
        chk("R8 luma clamp low", int'(out_c0), 16);

        // R8: mode 0 Cb offset 250 clamps to 240
        bank_wr(7'd14, 8'hFA);
        run_px(1'b1, 1'b0, 2'd0, 8'd0, 8'd0, 8'd0);
        chk_pix("R8 chroma clamp", 16, 240, 128);

        // R10: write beyond the bank is ignored
        bank_wr(7'd100, 8'h55);
        run_px(1'b1, 1'b0, 2'd0, 8'd0, 8'd0, 8'd0);
        chk_pix("R10 out of range write", 16, 240, 128);
        run_px(1'b1, 1'b0, 2'd1, 8'd255, 8'd255, 8'd255);
        chk_pix("R10 mode 1 untouched", 235, 128, 128);

        // R1: reset clears outputs and reloads defaults
        @(negedge clk);
        rst = 1'b1;
        drive(1'b1, 1'b0, 2'd0, 8'd50, 8'd50, 8'd50, 3'b111);
        repeat (2) @(negedge clk);
        chk_pix("R1 mid-run reset", 0, 0, 0);
        chk("R1 mid-run reset sync", int'({out_hs, out_vs, out_de}), 0);
        rst = 1'b0;
        run_px(1'b1, 1'b0, 2'd0, 8'd0, 8'd0, 8'd0);
        chk_pix("R1 mode 0 reloaded", 16, 128, 128);
        run_px(1'b1, 1'b0, 2'd2, 8'd3, 8'd0, 8'd0);
        chk_pix("R1 mode 2 reloaded", 19, 16, 16);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #(20 * 100000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule